// File: doc/BRIEF.md
# Transition-Started Read-Only Memory Read Port

This block is a clock-based model of a read-only memory read port that begins an access only when it sees one of its inputs move. On every clock edge it compares the 19-bit word address and the active-low chip select against the values it sampled on the edge before. A difference on either one launches a fresh array access, which takes a set number of cycles. Until such a difference has been seen, the port holds no valid word. This mimics a part whose output is undefined after power-up until the bus toggles.

The stored contents are a fixed function of the address, so no memory image is needed. The output buffer is sequenced separately from the array access. The active-low output enable, qualified by chip select, turns the buffer on after its own latency and turns it off a short time after either control goes inactive. `dq_drive` stands in for the tri-state buffer enable. `dq_valid` reports that a correct word sits on the bus.

All latencies are parameters counted in clock cycles. They are: address-started access (default 12), chip-select-started access (default 10), output-enable turn-on (default 4), turn-off (default 2) and old-data hold after an address change (default 0).

Top module: `atd_rom_port`

## Requirements
- R1: After a synchronous reset, `dq_valid` stays 0 and `dq` stays 0 for as long as `addr` and `ce_n` keep the values they had during reset, even with both enables low.
- R2: When `addr` changes while `ce_n` stays low, `dq_valid` rises T_ADDR edges after the first edge that sees the new address. `dq` then equals addr[7:0] ^ addr[15:8] ^ {5'b10100, addr[18:16]}.
- R3: When `ce_n` falls with `addr` unchanged, data is valid T_CE edges after the first edge that sees it low. If `addr` changes on that same edge, the larger of T_ADDR and T_CE applies.
- R4: A new address or chip-select transition during an access restarts the latency count from the beginning.
- R5: With `ce_n` high the port is in standby. Data validity is cleared at the first edge that sees `ce_n` high, and address changes start no access.
- R6: `dq_drive` rises T_OE edges after the first edge that sees both `ce_n` and `oe_n` low.
- R7: `dq_drive` falls T_DIS edges after the first edge that sees either `ce_n` or `oe_n` high. If both are low again before then, the buffer stays on.
- R8: With `ce_n` low and `oe_n` high, accesses still complete. Once `oe_n` goes low, the finished word appears as soon as the buffer turns on.
- R9: After an address change, old data stays valid for T_OH edges. With T_OH = 0, validity drops at the first edge that sees the change.
- R10: `dq_valid` is only ever high while `dq_drive` is high, and `dq` is 0 whenever `dq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, models power-up |
| addr | input | 19 | Word address |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| dq | output | 8 | Read data, 0 when not valid |
| dq_drive | output | 1 | Output buffer enable |
| dq_valid | output | 1 | Correct data present on `dq` |

## Verification
The bench first holds the inputs steady across reset. A port that reads the array unconditionally would show a valid word there without any transition. Every latency is probed one cycle before and on the cycle it should finish, so an off-by-one counter or a wrong choice between the address and chip-select latencies shows up. The bench moves the address in the middle of an access: a port that does not restart would present the abandoned address's word early. Further scenarios cover changes while in standby, accesses completing while the buffer is off, and a brief enable release inside the turn-off window. These catch a port that wakes from address noise, loses a finished word, or drops the bus needlessly.

// File: rtl/atd_rom_pkg.sv
package atd_rom_pkg;

    localparam int unsigned ADDR_W = 19;
    localparam int unsigned DATA_W = 8;

    // Output buffer sequencing states
    typedef enum logic [1:0] {
        DRV_OFF,
        DRV_RISE,
        DRV_ON,
        DRV_FALL
    } drv_state_e;

    // Per-edge transition report
    typedef struct packed {
        logic addr_chg;
        logic ce_chg;
        logic ce_fell;
        logic ce_on;
    } atd_event_t;

    // Array contents: a fixed mix of the address bits
    function automatic logic [DATA_W-1:0] rom_word(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b10100, a[18:16]};
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/atd_edge_detect.sv
module atd_edge_detect
    import atd_rom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    output atd_event_t        ev
);
    logic [ADDR_W-1:0] prev_addr;
    logic              prev_ce_n;

    // The history registers follow the inputs during reset as well, so the
    // first edge after reset reports a change only if an input really moved.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_addr <= addr;
            prev_ce_n <= ce_n;
        end else begin
            prev_addr <= addr;
            prev_ce_n <= ce_n;
        end
    end

    always_comb begin
        ev.addr_chg = (addr != prev_addr);
        ev.ce_chg   = (ce_n != prev_ce_n);
        ev.ce_fell  = ev.ce_chg && !ce_n;
        ev.ce_on    = !ce_n;
    end
endmodule

// File: rtl/atd_access_ctrl.sv
module atd_access_ctrl
    import atd_rom_pkg::*;
#(
    parameter int unsigned T_ADDR = 12,
    parameter int unsigned T_CE   = 10,
    parameter int unsigned T_OH   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  atd_event_t        ev,
    output logic              data_ok,
    output logic [DATA_W-1:0] word
);
    localparam int unsigned T_BOTH = max_u(T_ADDR, T_CE);
    localparam int unsigned CNT_W  = $clog2(T_BOTH + 1);
    localparam int unsigned HOLD_W = $clog2(T_OH + 2);
    localparam logic [CNT_W-1:0]  LAT_A = CNT_W'(T_ADDR);
    localparam logic [CNT_W-1:0]  LAT_C = CNT_W'(T_CE);
    localparam logic [CNT_W-1:0]  LAT_B = CNT_W'(T_BOTH);
    localparam logic [HOLD_W-1:0] HOLD  = HOLD_W'(T_OH);

    logic              busy;
    logic [CNT_W-1:0]  cnt;
    logic [HOLD_W-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt     <= '0;
            hold    <= '0;
            data_ok <= 1'b0;
            word    <= '0;
        end else if (!ev.ce_on) begin
            // standby: abandon everything
            busy    <= 1'b0;
            hold    <= '0;
            data_ok <= 1'b0;
        end else if (ev.addr_chg || ev.ce_chg) begin
            busy <= 1'b1;
            if (ev.ce_fell)
                cnt <= ev.addr_chg ? LAT_B : LAT_C;
            else
                cnt <= LAT_A;
            if ((T_OH > 0) && data_ok && !ev.ce_chg) begin
                hold <= HOLD;
            end else begin
                hold    <= '0;
                data_ok <= 1'b0;
            end
        end else begin
            if (hold != '0) begin
                if (hold == HOLD_W'(1))
                    data_ok <= 1'b0;
                hold <= hold - HOLD_W'(1);
            end
            if (busy) begin
                if (cnt == CNT_W'(1)) begin
                    busy    <= 1'b0;
                    data_ok <= 1'b1;
                    word    <= rom_word(addr);
                    hold    <= '0;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/atd_drive_seq.sv
module atd_drive_seq
    import atd_rom_pkg::*;
#(
    parameter int unsigned T_OE  = 4,
    parameter int unsigned T_DIS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic oe_n,
    output logic drive
);
    localparam int unsigned TMR_W = $clog2(max_u(T_OE, T_DIS) + 1);
    localparam logic [TMR_W-1:0] ON_LAT  = TMR_W'(T_OE);
    localparam logic [TMR_W-1:0] OFF_LAT = TMR_W'(T_DIS);

    drv_state_e       state;
    logic [TMR_W-1:0] tmr;
    logic             en;

    assign en    = !ce_n && !oe_n;
    assign drive = (state == DRV_ON) || (state == DRV_FALL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DRV_OFF;
            tmr   <= '0;
        end else begin
            unique case (state)
                DRV_OFF: if (en) begin
                    state <= DRV_RISE;
                    tmr   <= ON_LAT;
                end
                DRV_RISE: begin
                    if (!en)
                        state <= DRV_OFF;
                    else if (tmr == TMR_W'(1))
                        state <= DRV_ON;
                    else
                        tmr <= tmr - TMR_W'(1);
                end
                DRV_ON: if (!en) begin
                    state <= (T_DIS == 0) ? DRV_OFF : DRV_FALL;
                    tmr   <= OFF_LAT;
                end
                DRV_FALL: begin
                    if (en)
                        state <= DRV_ON;
                    else if (tmr == TMR_W'(1))
                        state <= DRV_OFF;
                    else
                        tmr <= tmr - TMR_W'(1);
                end
                default: state <= DRV_OFF;
            endcase
        end
    end
endmodule

// File: rtl/atd_rom_port.sv
module atd_rom_port
    import atd_rom_pkg::*;
#(
    parameter int unsigned T_ADDR = 12,
    parameter int unsigned T_CE   = 10,
    parameter int unsigned T_OE   = 4,
    parameter int unsigned T_DIS  = 2,
    parameter int unsigned T_OH   = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [18:0] addr,
    input  logic        ce_n,
    input  logic        oe_n,
    output logic [7:0]  dq,
    output logic        dq_drive,
    output logic        dq_valid
);
    atd_event_t        ev;
    logic              data_ok;
    logic [DATA_W-1:0] word;

    atd_edge_detect u_edge (
        .clk  (clk),
        .rst  (rst),
        .addr (addr),
        .ce_n (ce_n),
        .ev   (ev)
    );

    atd_access_ctrl #(
        .T_ADDR (T_ADDR),
        .T_CE   (T_CE),
        .T_OH   (T_OH)
    ) u_access (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .ev      (ev),
        .data_ok (data_ok),
        .word    (word)
    );

    atd_drive_seq #(
        .T_OE  (T_OE),
        .T_DIS (T_DIS)
    ) u_drive (
        .clk   (clk),
        .rst   (rst),
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .drive (dq_drive)
    );

    assign dq_valid = dq_drive && data_ok;
    assign dq       = dq_valid ? word : '0;
endmodule

// File: rtl/atd_rom_port_chk.sv
module atd_rom_port_chk
    import atd_rom_pkg::*;
#(
    parameter int unsigned T_DIS = 2
) (
    input logic        clk,
    input logic        rst,
    input logic [18:0] addr,
    input logic        ce_n,
    input logic        oe_n,
    input logic [7:0]  dq,
    input logic        dq_drive,
    input logic        dq_valid
);
    localparam int unsigned RUN_W = $clog2(T_DIS + 2) + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(T_DIS + 1);

    logic [RUN_W-1:0] off_run;
    logic [18:0]      p_addr;
    logic             p_ce_n;
    logic             seen;

    always_ff @(posedge clk) begin
        p_addr <= addr;
        p_ce_n <= ce_n;
        if (rst) begin
            off_run <= '0;
            seen    <= 1'b0;
        end else begin
            if (!ce_n && !oe_n)
                off_run <= '0;
            else if (off_run != RUN_MAX)
                off_run <= off_run + RUN_W'(1);
            if ((addr != p_addr) || (ce_n != p_ce_n))
                seen <= 1'b1;
        end
    end

    // R1: no valid word before any input transition since reset
    a_r1_no_early_data: assert property (@(posedge clk) disable iff (rst)
        !seen |-> !dq_valid);

    // R2: the word presented when validity rises matches the latched address
    a_r2_word_matches: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_valid) |-> dq == rom_word($past(addr)));

    // R5: chip select high clears validity at that edge
    a_r5_standby_clears: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> !dq_valid);

    // R7: buffer off once the disable window has run out
    a_r7_drive_released: assert property (@(posedge clk) disable iff (rst)
        (off_run == RUN_MAX) |-> !dq_drive);

    // R10: valid implies driven
    a_r10_valid_driven: assert property (@(posedge clk) disable iff (rst)
        dq_valid |-> dq_drive);

    // R10: bus quiet when not valid
    a_r10_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !dq_valid |-> dq == 8'h00);
endmodule

bind atd_rom_port atd_rom_port_chk #(.T_DIS(T_DIS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .dq       (dq),
    .dq_drive (dq_drive),
    .dq_valid (dq_valid)
);

// File: tb/sim_atd_rom_port.sv
module sim_atd_rom_port;
    logic        clk = 1'b0;
    logic        rst;
    logic [18:0] addr;
    logic        ce_n;
    logic        oe_n;
    logic [7:0]  dq;
    logic        dq_drive;
    logic        dq_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [18:0] A1 = 19'h4A5C3;
    localparam logic [18:0] A2 = 19'h00FF0;
    localparam logic [18:0] A3 = 19'h7FFFF;
    localparam logic [18:0] A4 = 19'h12C00;
    localparam logic [18:0] A5 = 19'h00000;
    localparam logic [18:0] A6 = 19'h55AA5;

    always #4 clk = ~clk;

    atd_rom_port u0 (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .dq       (dq),
        .dq_drive (dq_drive),
        .dq_valid (dq_valid)
    );

    function automatic logic [7:0] expect_word(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b10100, a[18:16]};
    endfunction

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; addr = 19'h12345; ce_n = 1'b0; oe_n = 1'b0;
        step(3);
        rst = 1'b0;
        step(20);
        check("R1 valid with no transition", dq_valid, 0);
        check("R1 dq with no transition", dq, 0);
        check("R6 drive on after steady enables", dq_drive, 1);
    endtask

    task automatic t_addr_access;
        addr = A1;
        step(12);
        check("R2 valid one cycle early", dq_valid, 0);
        step(1);
        check("R2 valid at address latency", dq_valid, 1);
        check("R2 word", dq, expect_word(A1));
    endtask

    task automatic t_restart;
        addr = A2;
        step(1);
        check("R9 validity drops on address change", dq_valid, 0);
        step(4);
        addr = A3;
        step(12);
        check("R4 restarted access not yet done", dq_valid, 0);
        step(1);
        check("R4 restarted access done", dq_valid, 1);
        check("R4 word of newest address", dq, expect_word(A3));
    endtask

    task automatic t_standby;
        ce_n = 1'b1;
        step(1);
        check("R5 standby clears valid", dq_valid, 0);
        check("R7 drive held in turn-off", dq_drive, 1);
        step(1);
        check("R7 drive held second cycle", dq_drive, 1);
        step(1);
        check("R7 drive released", dq_drive, 0);
        addr = A4;
        step(15);
        check("R5 address change in standby", dq_valid, 0);
        ce_n = 1'b0;
        step(4);
        check("R6 drive not yet on", dq_drive, 0);
        step(1);
        check("R6 drive on", dq_drive, 1);
        step(5);
        check("R3 chip-select access not yet done", dq_valid, 0);
        step(1);
        check("R3 chip-select access done", dq_valid, 1);
        check("R3 word", dq, expect_word(A4));
    endtask

    task automatic t_both_change;
        ce_n = 1'b1;
        step(3);
        ce_n = 1'b0; addr = A5;
        step(12);
        check("R3 combined change uses longer latency", dq_valid, 0);
        step(1);
        check("R3 combined change done", dq_valid, 1);
        check("R3 combined word", dq, expect_word(A5));
    endtask

    task automatic t_oe_high;
        oe_n = 1'b1;
        step(3);
        check("R7 output-enable release", dq_drive, 0);
        addr = A6;
        step(13);
        check("R10 no valid while undriven", dq_valid, 0);
        check("R10 dq quiet while undriven", dq, 0);
        oe_n = 1'b0;
        step(4);
        check("R8 buffer still turning on", dq_drive, 0);
        step(1);
        check("R8 finished word appears with buffer", dq_valid, 1);
        check("R8 word", dq, expect_word(A6));
    endtask

    task automatic t_blip;
        oe_n = 1'b1;
        step(1);
        oe_n = 1'b0;
        step(1);
        check("R7 re-enable inside turn-off keeps drive", dq_drive, 1);
        step(3);
        check("R7 drive stays on", dq_drive, 1);
        check("R8 data unaffected by enable blip", dq, expect_word(A6));
    endtask

    initial begin
        t_reset();
        t_addr_access();
        t_restart();
        t_standby();
        t_both_change();
        t_oe_high();
        t_blip();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL all requirements: watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule